// File: doc/BRIEF.md
# Dual-Loop Coarse/Fine Switch Controller

This block is the digital loop controller of a low-dropout regulator built from digitally switched power transistors. On every edge of a shift clock it moves one of two thermometer codes, each of which turns on a bank of power switches. The wide coarse code tracks the regulated output during start-up and load steps. The narrow fine code trims the output in steady state while the coarse code stays frozen. A one-bit direction input comes from an external comparator. It is high when the output is below the reference, which asks for more switches, and low when the output is above it, which asks for fewer.

A lock flag picks the active loop. When lock is low the coarse register follows the direction input. When lock rises, the fine register is loaded to mid-scale so that trimming can go either way. When lock falls, the coarse register continues from the code it held before it was frozen. An active-high enable stops both loops. The comparator, the lock detection and the clock generation sit outside this block.

Top module: `dlc_dual_loop_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both the coarse code and the fine code to all zeros.
- R2: Both codes are always thermometer codes: the ones form one contiguous run starting at bit 0.
- R3: With enable high, lock low and the direction input high, each clock edge adds one more switch to the coarse code at the bit just above its highest one. A coarse code of all ones stays all ones.
- R4: With enable high, lock low and the direction input low, each clock edge removes the highest one of the coarse code. A coarse code of all zeros stays all zeros.
- R5: While lock is high at a clock edge, the coarse code does not change on that edge.
- R6: While lock is low at a clock edge, the fine code does not change on that edge.
- R7: On the first edge at which lock is high after an edge at which it was low, or after reset, the fine code is loaded with its lower half set to ones (16 ones at the default width of 32). This load happens whatever the enable and direction inputs are, and the fine code takes no step on that edge.
- R8: On later edges while lock stays high and enable is high, the fine code steps by the same rules as R3 and R4, saturating at all ones and at all zeros.
- R9: With enable low, neither code takes a step, whatever the direction input is. The lock-rise load of R7 still happens.
- R10: When lock falls, the coarse code continues stepping from the value it held while frozen, and the fine code keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows stepping when high |
| up_dn | input | 1 | High: output below the reference, add switches; low: remove switches |
| lock | input | 1 | Low selects the coarse loop; high freezes the coarse code and selects the fine loop |
| coarse_code | output | 64 | Coarse thermometer code, bit 0 fills first |
| fine_code | output | 32 | Fine thermometer code, bit 0 fills first |

## Verification
Every register drives an output directly, so a wrong internal state shows at the ports on the very next clock edge. A miscounted step shows as a one-count error in a code. A broken saturation shows as a code that wraps around, or as a code that is no longer a thermometer code. A lost lock edge shows as a fine code that is not at mid-scale one edge after lock rises. A loop that ignores the lock or enable inputs shows as a code that moves when it should hold. The bench compares both full codes against thermometer values after each edge. The step sequences cover both saturation limits, relocking with the enable low, and resuming the coarse loop after lock falls.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    localparam int COARSE_BITS = 64;
    localparam int FINE_BITS   = 32;

    // Operation applied to one thermometer register on a clock edge
    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_FILL  = 2'd1,
        STEP_DRAIN = 2'd2,
        STEP_LOAD  = 2'd3
    } step_e;

    typedef struct packed {
        step_e coarse_op;
        step_e fine_op;
    } loop_cmd_t;

    // Direction to operation for an active loop
    function automatic step_e pick_step(input logic active, input logic up);
        if (!active)
            return STEP_HOLD;
        return up ? STEP_FILL : STEP_DRAIN;
    endfunction

endpackage

// File: rtl/dlc_loop_select.sv
module dlc_loop_select
    import dlc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      up_dn,
    input  logic      lock,
    output loop_cmd_t cmd
);

    logic lock_q;
    logic lock_rise;

    always_ff @(posedge clk) begin
        if (rst)
            lock_q <= 1'b0;
        else
            lock_q <= lock;
    end

    assign lock_rise = lock && !lock_q;

    always_comb begin
        cmd.coarse_op = pick_step(enable && !lock, up_dn);
        if (lock_rise)
            cmd.fine_op = STEP_LOAD;
        else
            cmd.fine_op = pick_step(enable && lock, up_dn);
    end

endmodule

// File: rtl/dlc_therm_shifter.sv
module dlc_therm_shifter
    import dlc_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int PRESET_ONES = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            op,
    output logic [WIDTH-1:0] code
);

    function automatic logic [WIDTH-1:0] low_ones(input int n);
        logic [WIDTH-1:0] v;
        for (int i = 0; i < WIDTH; i++)
            v[i] = (i < n);
        return v;
    endfunction

    localparam logic [WIDTH-1:0] PRESET = low_ones(PRESET_ONES);

    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] code_d;

    // A fill shifts a one in at bit 0; a drain shifts a zero in at the top.
    // Both saturate on their own at all ones / all zeros.
    always_comb begin
        unique case (op)
            STEP_FILL:  code_d = {code_q[WIDTH-2:0], 1'b1};
            STEP_DRAIN: code_d = {1'b0, code_q[WIDTH-1:1]};
            STEP_LOAD:  code_d = PRESET;
            default:    code_d = code_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else
            code_q <= code_d;
    end

    assign code = code_q;

endmodule

// File: rtl/dlc_dual_loop_ctrl.sv
module dlc_dual_loop_ctrl
    import dlc_pkg::*;
#(
    parameter int COARSE_W = COARSE_BITS,
    parameter int FINE_W   = FINE_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                up_dn,
    input  logic                lock,
    output logic [COARSE_W-1:0] coarse_code,
    output logic [FINE_W-1:0]   fine_code
);

    localparam int FINE_MID = FINE_W / 2;

    loop_cmd_t cmd;

    dlc_loop_select u_sel (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .up_dn  (up_dn),
        .lock   (lock),
        .cmd    (cmd)
    );

    dlc_therm_shifter #(
        .WIDTH       (COARSE_W),
        .PRESET_ONES (0)
    ) u_coarse (
        .clk  (clk),
        .rst  (rst),
        .op   (cmd.coarse_op),
        .code (coarse_code)
    );

    dlc_therm_shifter #(
        .WIDTH       (FINE_W),
        .PRESET_ONES (FINE_MID)
    ) u_fine (
        .clk  (clk),
        .rst  (rst),
        .op   (cmd.fine_op),
        .code (fine_code)
    );

endmodule

// File: rtl/dlc_dual_loop_chk.sv
module dlc_dual_loop_chk #(
    parameter int CW = 64,
    parameter int FW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          enable,
    input logic          up_dn,
    input logic          lock,
    input logic [CW-1:0] coarse_code,
    input logic [FW-1:0] fine_code
);

    function automatic logic [FW-1:0] fine_mid();
        logic [FW-1:0] v;
        for (int i = 0; i < FW; i++)
            v[i] = (i < FW / 2);
        return v;
    endfunction

    localparam logic [FW-1:0] MID = fine_mid();

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (coarse_code == '0 && fine_code == '0));

    assert_coarse_therm_R2: assert property (@(posedge clk) disable iff (rst)
        (coarse_code & (coarse_code + CW'(1))) == '0);

    assert_fine_therm_R2: assert property (@(posedge clk) disable iff (rst)
        (fine_code & (fine_code + FW'(1))) == '0);

    assert_coarse_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && !lock && up_dn && !(&coarse_code))
        |=> coarse_code == {$past(coarse_code[CW-2:0]), 1'b1});

    assert_coarse_drain_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && !lock && !up_dn)
        |=> coarse_code == {1'b0, $past(coarse_code[CW-1:1])});

    assert_coarse_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(coarse_code));

    assert_fine_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !lock |=> $stable(fine_code));

    assert_fine_preload_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |=> fine_code == MID);

    assert_fine_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (enable && lock && $past(lock) && up_dn && !(&fine_code))
        |=> fine_code == {$past(fine_code[FW-2:0]), 1'b1});

    assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(coarse_code));

endmodule

bind dlc_dual_loop_ctrl dlc_dual_loop_chk #(
    .CW (COARSE_W),
    .FW (FINE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .up_dn       (up_dn),
    .lock        (lock),
    .coarse_code (coarse_code),
    .fine_code   (fine_code)
);

// File: tb/tb_dlc_dual_loop_ctrl.sv
module tb_dlc_dual_loop_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic        up_dn;
    logic        lock;
    logic [63:0] coarse_code;
    logic [31:0] fine_code;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    dlc_dual_loop_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .up_dn       (up_dn),
        .lock        (lock),
        .coarse_code (coarse_code),
        .fine_code   (fine_code)
    );

    // Vector: {enable, up_dn, lock, coarse ones[6:0], fine ones[5:0]}
    localparam int NVEC = 15;
    localparam logic [15:0] VEC [NVEC] = '{
        {3'b110, 7'd1,  6'd0},   // R3 fill
        {3'b110, 7'd2,  6'd0},   // R3
        {3'b110, 7'd3,  6'd0},   // R3
        {3'b100, 7'd2,  6'd0},   // R4 drain
        {3'b010, 7'd2,  6'd0},   // R9 hold
        {3'b111, 7'd2,  6'd16},  // R7 preload, R5
        {3'b111, 7'd2,  6'd17},  // R8
        {3'b111, 7'd2,  6'd18},  // R8
        {3'b111, 7'd2,  6'd19},  // R8
        {3'b111, 7'd2,  6'd20},  // R8
        {3'b011, 7'd2,  6'd20},  // R9 locked hold
        {3'b100, 7'd1,  6'd20},  // R10 resume, R6
        {3'b110, 7'd2,  6'd20},  // R10
        {3'b001, 7'd2,  6'd16},  // R7 preload with enable low
        {3'b101, 7'd2,  6'd15}   // R8 drain
    };

    function automatic logic [63:0] therm64(input int n);
        logic [63:0] v;
        for (int i = 0; i < 64; i++)
            v[i] = (i < n);
        return v;
    endfunction

    function automatic logic [31:0] therm32(input int n);
        logic [31:0] v;
        for (int i = 0; i < 32; i++)
            v[i] = (i < n);
        return v;
    endfunction

    task automatic check_codes(input string req, input int c_n, input int f_n);
        checks++;
        if (coarse_code !== therm64(c_n)) begin
            failures++;
            $display("FAIL %s coarse actual=%h expected=%h", req, coarse_code, therm64(c_n));
        end
        checks++;
        if (fine_code !== therm32(f_n)) begin
            failures++;
            $display("FAIL %s fine actual=%h expected=%h", req, fine_code, therm32(f_n));
        end
    endtask

    task automatic step(input logic en, input logic up, input logic lk);
        enable = en;
        up_dn  = up;
        lock   = lk;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #2ms;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b0; up_dn = 1'b0; lock = 1'b0;
        @(negedge clk);
        do_reset();
        check_codes("R1 reset", 0, 0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][15], VEC[i][14], VEC[i][13]);
            check_codes($sformatf("vec%0d R3/R4/R5/R6/R7/R8/R9/R10", i),
                        int'(VEC[i][12:6]), int'(VEC[i][5:0]));
        end

        // R1: reset in the middle of operation
        do_reset();
        check_codes("R1 mid reset", 0, 0);

        // R3: coarse saturates at all ones
        for (int i = 0; i < 70; i++) step(1'b1, 1'b1, 1'b0);
        check_codes("R3 coarse saturate high", 64, 0);
        // R4: coarse saturates at all zeros
        for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 1'b0);
        check_codes("R4 coarse saturate low", 0, 0);
        step(1'b1, 1'b0, 1'b0);
        check_codes("R4 coarse stays zero", 0, 0);

        // R7 then R8: fine saturates at both ends, R5 coarse stays frozen
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0);
        check_codes("R3 coarse before lock", 5, 0);
        step(1'b1, 1'b0, 1'b1);
        check_codes("R7 preload ignores direction", 5, 16);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1);
        check_codes("R8 fine saturate high R5", 5, 32);
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b1);
        check_codes("R8 fine saturate low R5", 5, 0);
        step(1'b1, 1'b0, 1'b0);
        check_codes("R10 coarse resumes from frozen", 4, 0);

        // R7: lock held high through reset release preloads on first edge
        rst = 1'b1;
        step(1'b0, 1'b0, 1'b1);
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b1);
        check_codes("R7 preload after reset", 0, 16);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule